// File: doc/BRIEF.md
# Rotating Pattern Multiphase Clock Generator

This block produces periodic waveforms by rotating stored bit patterns instead of counting and comparing. Each of several lanes holds a short pattern. On every tick of a programmable prescaler, the low `L` bits of each lane rotate right by one place, and bit 0 wraps into bit `L-1`. The lane's waveform is its bit 0. A 12-bit pattern of six ones and six zeros therefore gives a clock at one twelfth of the tick rate with an even duty cycle. Loading rotated copies of that pattern into other lanes gives phase-shifted copies of the same clock.

A single load strobe captures the whole configuration: the prescaler period and start delay, the loop length, the mode code, the lane patterns, and the per-output lane select and enable. The same strobe restarts the prescaler. A mode code other than rotate-right-repeat freezes every lane. Each external output is driven by the lane its selector names, or by 0 when its enable is clear.

Top module: `pattern_phase_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the lanes, the prescaler count and all captured configuration, including selects and enables. `data_out` reads 0 on the cycle after a reset edge.
- R2: When `cfg_load` is high at a clock edge, the lanes are loaded from `pat_words` as follows: lane 0 from bits [11:0], lane 1 from [27:16], lane 2 from [43:32] and lane 3 from [59:48]. On the cycle after that edge, each enabled output already shows bit 0 of its selected lane.
- R3: With a period setting of 0, the lanes advance on every clock edge after the load edge.
- R4: With a period setting P, consecutive advances are P+1 clock edges apart.
- R5: With an offset setting O, the first advance comes at edge O+P+1 after the load edge. After k edges the lanes have advanced 0 times if k < O+P+1, and otherwise 1+(k-O-P-1)/(P+1) times.
- R6: Mode code 3 rotates the low L bits right and wraps bit 0 into bit L-1. After n advances a lane's output equals its loaded bit (n mod L). The four 12-bit patterns 0x07E, 0x1F8, 0x7E0 and 0xF81 give divide-by-12 clocks with even duty and phases 0, 2, 4 and 6 cycles.
- R7: A length setting of 0 or 1 acts as 1, so the output holds the loaded bit 0.
- R8: A length setting above the lane width (12) acts as the lane width.
- R9: Any mode code other than 3 holds every lane unchanged, so the outputs stay at the loaded bit 0.
- R10: Output j is driven by lane n, where n is the value in `out_sel[2j+1:2j]`.
- R11: When bit j of the captured `out_en` is 0, `data_out[j]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration, load lanes, restart prescaler |
| div_period | input | DIV_W | Prescaler period; ticks every period+1 cycles |
| div_offset | input | DIV_W | Extra cycles before the first tick after a load |
| bit_len | input | LEN_W | Number of lane bits taking part in the rotation |
| mode | input | MODE_W | 3 = rotate right repeat, others hold |
| pat_words | input | NWORDS*WORD_W | Packed pattern words, two lanes per word |
| out_sel | input | LANES*SEL_W | Per-output lane select |
| out_en | input | LANES | Per-output enable; clear forces 0 |
| data_out | output | LANES | Generated waveforms |

## Verification
The bench builds the block with four 12-bit lanes, 32-bit pattern words and a 4-bit prescaler, in place of the default 8 bits. This keeps the largest period and offset, 15 each, inside runs of about a hundred cycles, so the delayed first tick and the widest tick spacing are both reached. The 5-bit length field can exceed the lane width, which exercises the upper clamp as well as the 0 and 1 cases. The 2-bit selects cover every lane-to-output mapping, including reversed and repeated mappings.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int MODE_ROTR = 3;

  // effective loop length: at least 1, at most the lane width
  function automatic int unsigned clamp_len(int unsigned raw, int unsigned width);
    if (raw < 2) return 1;
    if (raw > width) return width;
    return raw;
  endfunction
endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W:0]   restart_span,
  input  logic [DIV_W-1:0] period_q,
  output logic             tick
);
  logic [DIV_W:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= restart_span;
    else if (tick)    cnt_q <= {1'b0, period_q};
    else              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ppg_lane.sv
module ppg_lane #(
  parameter int W     = 12,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             advance,
  input  logic [LEN_W-1:0] len_eff,
  output logic [W-1:0]     lane_q
);
  function automatic logic [W-1:0] rot_right(logic [W-1:0] v, logic [LEN_W-1:0] n);
    logic [W-1:0] r;
    int unsigned  nn;
    nn = int'(n);
    r  = v;
    for (int i = 0; i < W; i++) begin
      if (i + 1 < nn)       r[i] = v[i+1];
      else if (i + 1 == nn) r[i] = v[0];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          lane_q <= '0;
    else if (load)    lane_q <= load_val;
    else if (advance) lane_q <= rot_right(lane_q, len_eff);
  end
endmodule

// File: rtl/ppg_outmux.sv
module ppg_outmux #(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic [LANES-1:0]       lane_lsb,
  input  logic [LANES*SEL_W-1:0] sel_q,
  input  logic [LANES-1:0]       en_q,
  output logic [LANES-1:0]       data_out
);
  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [SEL_W-1:0] pick;
    assign pick        = sel_q[j*SEL_W +: SEL_W];
    assign data_out[j] = en_q[j] & lane_lsb[pick];
  end
endmodule

// File: rtl/pattern_phase_gen.sv
module pattern_phase_gen #(
  parameter int LANES  = 4,
  parameter int LANE_W = 12,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 5,
  parameter int MODE_W = 3,
  localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int NWORDS = (LANES + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_load,
  input  logic [DIV_W-1:0]          div_period,
  input  logic [DIV_W-1:0]          div_offset,
  input  logic [LEN_W-1:0]          bit_len,
  input  logic [MODE_W-1:0]         mode,
  input  logic [NWORDS*WORD_W-1:0]  pat_words,
  input  logic [LANES*SEL_W-1:0]    out_sel,
  input  logic [LANES-1:0]          out_en,
  output logic [LANES-1:0]          data_out
);
  localparam int HALF = WORD_W / 2;

  logic [DIV_W-1:0]       period_q;
  logic [LEN_W-1:0]       len_q;
  logic [MODE_W-1:0]      mode_q;
  logic [LANES*SEL_W-1:0] sel_q;
  logic [LANES-1:0]       en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      len_q    <= '0;
      mode_q   <= '0;
      sel_q    <= '0;
      en_q     <= '0;
    end else if (cfg_load) begin
      period_q <= div_period;
      len_q    <= bit_len;
      mode_q   <= mode;
      sel_q    <= out_sel;
      en_q     <= out_en;
    end
  end

  // named internal events for the checker
  logic                    tick;
  logic                    rot_en;
  logic                    advance;
  logic [LEN_W-1:0]        len_eff;
  logic [DIV_W:0]          load_span;
  logic [LANES-1:0]        lane_lsb;
  logic [LANES*LANE_W-1:0] lanes_flat;

  assign rot_en    = (mode_q == MODE_W'(ppg_pkg::MODE_ROTR));
  assign advance   = tick & rot_en;
  assign len_eff   = LEN_W'(ppg_pkg::clamp_len(int'(len_q), LANE_W));
  assign load_span = {1'b0, div_offset} + {1'b0, div_period};

  ppg_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk          (clk),
    .rst          (rst),
    .restart      (cfg_load),
    .restart_span (load_span),
    .period_q     (period_q),
    .tick         (tick)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    ppg_lane #(.W(LANE_W), .LEN_W(LEN_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (cfg_load),
      .load_val (pat_words[(j/2)*WORD_W + (j%2)*HALF +: LANE_W]),
      .advance  (advance),
      .len_eff  (len_eff),
      .lane_q   (lane_q)
    );
    assign lane_lsb[j]                     = lane_q[0];
    assign lanes_flat[j*LANE_W +: LANE_W]  = lane_q;
  end

  ppg_outmux #(.LANES(LANES), .SEL_W(SEL_W)) u_mux (
    .lane_lsb (lane_lsb),
    .sel_q    (sel_q),
    .en_q     (en_q),
    .data_out (data_out)
  );
endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 12,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 5,
  parameter int NWORDS = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_load,
  input logic                      tick,
  input logic                      rot_en,
  input logic [DIV_W-1:0]          period_q,
  input logic [LEN_W-1:0]          len_eff,
  input logic [LANES-1:0]          en_q,
  input logic [LANES-1:0]          lane_lsb,
  input logic [LANES*LANE_W-1:0]   lanes_flat,
  input logic [NWORDS*WORD_W-1:0]  pat_words,
  input logic [LANES-1:0]          data_out
);
  localparam int HALF = WORD_W / 2;

  logic [LANES-1:0] first_bits;
  always_comb begin
    for (int j = 0; j < LANES; j++)
      first_bits[j] = pat_words[(j/2)*WORD_W + (j%2)*HALF];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> data_out == '0);

  // R2
  load_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> lane_lsb == $past(first_bits));

  // R3
  every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    tick && period_q == '0 && !cfg_load |=> tick);

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick && period_q != '0 && !cfg_load |=> !tick);

  // R7
  short_len_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load && len_eff == LEN_W'(1) |=> $stable(lanes_flat));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    len_eff != '0 && int'(len_eff) <= LANE_W);

  // R9
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load && !rot_en |=> $stable(lanes_flat));

  // R11
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (data_out & ~en_q) == '0);
endmodule

bind pattern_phase_gen ppg_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .WORD_W(WORD_W),
  .DIV_W(DIV_W), .LEN_W(LEN_W), .NWORDS(NWORDS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .tick       (tick),
  .rot_en     (rot_en),
  .period_q   (period_q),
  .len_eff    (len_eff),
  .en_q       (en_q),
  .lane_lsb   (lane_lsb),
  .lanes_flat (lanes_flat),
  .pat_words  (pat_words),
  .data_out   (data_out)
);

// File: tb/pattern_phase_gen_bench.sv
module pattern_phase_gen_bench;
  localparam int LANES = 4, LANE_W = 12, WORD_W = 32, DIV_W = 4;
  localparam int LEN_W = 5, MODE_W = 3, SEL_W = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst = 1'b1;
  logic                   cfg_load = 1'b0;
  logic [DIV_W-1:0]       div_period = '0;
  logic [DIV_W-1:0]       div_offset = '0;
  logic [LEN_W-1:0]       bit_len = '0;
  logic [MODE_W-1:0]      mode = '0;
  logic [2*WORD_W-1:0]    pat_words = '0;
  logic [LANES*SEL_W-1:0] out_sel = '0;
  logic [LANES-1:0]       out_en = '0;
  logic [LANES-1:0]       data_out;

  pattern_phase_gen #(
    .LANES(LANES), .LANE_W(LANE_W), .WORD_W(WORD_W),
    .DIV_W(DIV_W), .LEN_W(LEN_W), .MODE_W(MODE_W)
  ) u_pattern_phase_gen (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .div_period(div_period),
    .div_offset(div_offset), .bit_len(bit_len), .mode(mode),
    .pat_words(pat_words), .out_sel(out_sel), .out_en(out_en),
    .data_out(data_out)
  );

  int checks = 0;
  int errors = 0;

  // reference state captured at each load
  logic [LANE_W-1:0] m_pat [LANES];
  int                m_p, m_o, m_l;
  bit                m_rot;
  logic [LANES*SEL_W-1:0] m_sel;
  logic [LANES-1:0]       m_en;

  function automatic int advances_after(int k);
    int first;
    first = m_o + m_p + 1;
    if (k < first) return 0;
    return 1 + (k - first) / (m_p + 1);
  endfunction

  function automatic logic [LANES-1:0] expect_out(int k);
    logic [LANES-1:0] e;
    int n, idx, s;
    n   = m_rot ? advances_after(k) : 0;
    idx = n % m_l;
    for (int j = 0; j < LANES; j++) begin
      s    = int'(m_sel[j*SEL_W +: SEL_W]);
      e[j] = m_en[j] & m_pat[s][idx];
    end
    return e;
  endfunction

  task automatic check(string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data_out=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply_cfg(int p, int o, int l, int md, logic [WORD_W-1:0] w0,
                           logic [WORD_W-1:0] w1, logic [LANES*SEL_W-1:0] sel,
                           logic [LANES-1:0] en);
    @(negedge clk);
    div_period = DIV_W'(p);
    div_offset = DIV_W'(o);
    bit_len    = LEN_W'(l);
    mode       = MODE_W'(md);
    pat_words  = {w1, w0};
    out_sel    = sel;
    out_en     = en;
    cfg_load   = 1'b1;
    m_p = p; m_o = o;
    m_l = (l < 2) ? 1 : ((l > LANE_W) ? LANE_W : l);
    m_rot = (md == 3);
    m_sel = sel; m_en = en;
    for (int j = 0; j < LANES; j++)
      m_pat[j] = pat_words[(j/2)*WORD_W + (j%2)*(WORD_W/2) +: LANE_W];
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_and_check(string tag, int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      check(tag, data_out, expect_out(k));
      @(negedge clk);
    end
  endtask

  localparam logic [LANES*SEL_W-1:0] SEL_ID  = {2'd3, 2'd2, 2'd1, 2'd0};
  localparam logic [LANES*SEL_W-1:0] SEL_REV = {2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [WORD_W-1:0] W0_PH = {4'h0, 12'b0001_1111_1000, 4'h0, 12'b0000_0111_1110};
  localparam logic [WORD_W-1:0] W1_PH = {4'h0, 12'b1111_1000_0001, 4'h0, 12'b0111_1110_0000};

  initial begin
    void'($urandom(32'h5eed_0c1c));
    repeat (3) @(negedge clk);
    check("R1 reset", data_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", data_out, '0);

    // four-phase divide-by-12 clocks, phase steps of 2 cycles
    apply_cfg(0, 0, 12, 3, W0_PH, W1_PH, SEL_ID, 4'hF);
    run_and_check("R2 R3 R6 four-phase", 36);

    // reversed and repeated mapping with partial enable
    apply_cfg(0, 0, 12, 3, W0_PH, W1_PH, SEL_REV, 4'b1010);
    run_and_check("R10 R11 reversed", 24);
    apply_cfg(0, 0, 12, 3, W0_PH, W1_PH, {2'd2, 2'd2, 2'd1, 2'd1}, 4'b0111);
    run_and_check("R10 R11 repeated", 24);

    // slower ticks
    apply_cfg(2, 0, 12, 3, W0_PH, W1_PH, SEL_ID, 4'hF);
    run_and_check("R4 period 2", 48);

    // delayed first tick
    apply_cfg(1, 3, 7, 3, 32'h0ABC_0123, 32'h0F0F_0555, SEL_ID, 4'hF);
    run_and_check("R5 offset 3", 40);

    // short loop lengths hold
    apply_cfg(0, 0, 1, 3, 32'h0001_0FFE, 32'h0FFF_0000, SEL_ID, 4'hF);
    run_and_check("R7 length 1", 16);
    apply_cfg(0, 0, 0, 3, 32'h0FFE_0001, 32'h0000_0FFF, SEL_ID, 4'hF);
    run_and_check("R7 length 0", 16);

    // lengths beyond the lane clamp to 12
    apply_cfg(0, 0, 31, 3, 32'h0C35_0A96, 32'h0701_0E2B, SEL_ID, 4'hF);
    run_and_check("R8 length 31", 30);
    apply_cfg(0, 0, 13, 3, 32'h0C35_0A96, 32'h0701_0E2B, SEL_ID, 4'hF);
    run_and_check("R8 length 13", 30);

    // non-rotate modes freeze
    apply_cfg(0, 0, 12, 0, 32'h0FFE_0001, 32'h0000_0FFF, SEL_ID, 4'hF);
    run_and_check("R9 mode 0", 16);
    apply_cfg(0, 0, 12, 7, 32'h0FFE_0001, 32'h0000_0FFF, SEL_ID, 4'hF);
    run_and_check("R9 mode 7", 16);

    // widest spacing and delay
    apply_cfg(15, 15, 5, 3, 32'h0013_0017, 32'h0009_001E, SEL_ID, 4'hF);
    run_and_check("R4 R5 max", 110);

    // reset in the middle of a run
    apply_cfg(0, 0, 12, 3, W0_PH, W1_PH, SEL_ID, 4'hF);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", data_out, '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stays cleared", data_out, '0);

    // constrained random configurations
    for (int t = 0; t < 40; t++) begin
      int p, o, l, md;
      p  = int'($urandom_range(0, 3));
      o  = int'($urandom_range(0, 5));
      l  = int'($urandom_range(0, 31));
      md = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : 3;
      apply_cfg(p, o, l, md, $urandom, $urandom, LANES*SEL_W'($urandom),
                LANES'($urandom));
      run_and_check("R2 R4 R5 R6 R10 R11 random", 40);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule